// File: doc/BRIEF.md
# Byte-Serial Code Memory Loader

This block lets a host fill the code memory of an embedded microcontroller one byte at a time through a single 32-bit register. It also lets the host read the stored image back for checking. Each word the host writes holds three things. The top byte selects a mode, the next byte is a data value, and the low bits give a byte address. While the loader is in its upload mode, the microcontroller is held in reset. Every byte written goes into an on-chip code RAM. Every read of the register returns the byte under an internal pointer and then moves the pointer forward by one, so the host can walk through the whole image to verify it.

The host may write only the low byte of the address. The upper address bits always come from the internal pointer. A host therefore detects a write that went to the wrong 256-byte page by reading the address back. After loading, the host writes two closing modes. The first records the image length. The second declares the image good and lets the microcontroller run. The microcontroller fetches through a separate read port on the same RAM.

Top module: `fw_load_port`

## Requirements
- R1: After reset the mode is upload (0x0F), the pointer is 0, `core_hold` is 1 and `bus_rvalid` is 0. The first read after reset returns 0x0F in bits 31:24 and 0 in bits 15:0.
- R2: A write with bits 31:24 = 0x0F stores bits 23:16 into the code RAM at address {pointer[ADDR_W-1:8], wdata[7:0]}. It also sets the pointer to that address, so the next read returns the stored byte.
- R3: A read in upload mode sets `bus_rvalid` one cycle later. `bus_rdata` then holds {0x0F, byte at pointer, 2'b00, pointer zero-extended to 14 bits}, and the pointer advances by one.
- R4: The pointer wraps from 2^ADDR_W-1 to 0 on a read.
- R5: Write bits 15:8 never select the page, and bits 15:14 of readback are always 0. A write naming a page other than the pointer's page lands in the pointer's page, and the readback shows the pointer's page.
- R6: A write with mode 0x03 keeps `core_hold` at 1, leaves the RAM unchanged and latches bits ADDR_W:0 as the image length. Reads then return {0x03, 0x00, length zero-extended to 16 bits} and do not move the pointer.
- R7: A write with mode 0x13 drops `core_hold` in the next cycle and latches the length the same way. Reads return {0x13, 0x00, length}.
- R8: A write whose mode byte is not 0x03, 0x0F or 0x13 changes nothing: not the mode, the pointer, the RAM or `core_hold`.
- R9: A write with mode 0x0F from any mode returns the loader to upload mode and raises `core_hold` in the next cycle.
- R10: When a read and a write arrive in the same cycle, the read returns the state from before the write. The pointer then ends at the write address.
- R11: `core_data` returns the RAM byte at `core_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per word |
| bus_rd | input | 1 | Register read strobe, one cycle per word |
| bus_wdata | input | 32 | Write word {mode, data byte, address bits} |
| bus_rdata | output | 32 | Read word, valid when `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| core_hold | output | 1 | Holds the microcontroller in reset while high |
| core_addr | input | ADDR_W | Microcontroller fetch address |
| core_data | output | 8 | Fetched code byte, one cycle after `core_addr` |

## Verification
A read and a write can share a cycle. The read then wants to advance the pointer while the write wants to set it, and the RAM port also has to write and read the same location in that cycle. The bench drives both strobes on one edge, with a write address far from the current pointer. It expects that cycle's read word to carry the old pointer and the old byte. It expects the following two reads to return the newly written byte at the written address, and then the byte after it. It compares all of these against its own model of the RAM.

// File: rtl/fw_load_pkg.sv
package fw_load_pkg;
  localparam int REG_W       = 32;
  localparam int BYTE_W      = 8;
  localparam int PTR_FIELD_W = 14;
  localparam int CNT_FIELD_W = 16;

  typedef enum logic [7:0] {
    MODE_LOADED   = 8'h03,
    MODE_UPLOAD   = 8'h0F,
    MODE_VERIFIED = 8'h13
  } mode_e;
endpackage

// File: rtl/fw_load_ram.sv
// Code RAM: port A is read/write with write-first data, port B is read-only.
module fw_load_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_addr] <= a_din;
      a_dout      <= a_din;
    end else begin
      a_dout      <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    b_dout <= mem[b_addr];
  end
endmodule

// File: rtl/fw_load_ctrl.sv
// Mode decode, pointer sequencing, length latch and core reset control.
module fw_load_ctrl
  import fw_load_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  wdata,
  output mode_e             mode_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [ADDR_W:0]   cnt_q,
  output logic              hold_q,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_byte
);
  localparam int CNT_W = ADDR_W + 1;

  logic [7:0]        wmode;
  logic              load_wr, close_wr, upload;
  logic [ADDR_W-1:0] wr_addr, ptr_d;
  mode_e             mode_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              unused_hi;

  assign wmode    = wdata[31:24];
  assign load_wr  = wr && (wmode == MODE_UPLOAD);
  assign close_wr = wr && ((wmode == MODE_LOADED) || (wmode == MODE_VERIFIED));
  assign upload   = (mode_q == MODE_UPLOAD);
  // Page bits come from the pointer; only the low byte is host-writable.
  assign wr_addr  = {ptr_q[ADDR_W-1:BYTE_W], wdata[BYTE_W-1:0]};
  assign unused_hi = ^wdata[15:CNT_W];

  always_comb begin
    ptr_d = ptr_q;
    if (load_wr)           ptr_d = wr_addr;
    else if (rd && upload) ptr_d = ptr_q + 1'b1;
  end

  always_comb begin
    mode_d = mode_q;
    if (load_wr)       mode_d = MODE_UPLOAD;
    else if (close_wr) mode_d = mode_e'(wmode);
  end

  assign cnt_d = close_wr ? wdata[CNT_W-1:0] : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_UPLOAD;
      ptr_q  <= '0;
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      hold_q <= (mode_d != MODE_VERIFIED);
    end
  end

  // The RAM address tracks the next pointer, so port A always holds mem[ptr_q].
  assign ram_we   = load_wr && !rst;
  assign ram_addr = rst ? '0 : ptr_d;
  assign ram_byte = wdata[23:16];
endmodule

// File: rtl/fw_load_port.sv
// Top: register read path around the control and code RAM.
module fw_load_port
  import fw_load_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              core_hold,
  input  logic [ADDR_W-1:0] core_addr,
  output logic [7:0]        core_data
);
  mode_e             mode_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W:0]   cnt_q;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [BYTE_W-1:0] ram_byte, ram_at_ptr;
  logic [31:0]       rd_word;

  fw_load_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .ptr_q    (ptr_q),
    .cnt_q    (cnt_q),
    .hold_q   (core_hold),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .ram_byte (ram_byte)
  );

  fw_load_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk    (clk),
    .a_we   (ram_we),
    .a_addr (ram_addr),
    .a_din  (ram_byte),
    .a_dout (ram_at_ptr),
    .b_addr (core_addr),
    .b_dout (core_data)
  );

  always_comb begin
    if (mode_q == MODE_UPLOAD)
      rd_word = {mode_q, ram_at_ptr, 2'b00, PTR_FIELD_W'(ptr_q)};
    else
      rd_word = {mode_q, 8'h00, CNT_FIELD_W'(cnt_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/fw_load_port_chk.sv
module fw_load_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        core_hold
);
  logic rst_d = 1'b0;
  logic known_mode;

  always_ff @(posedge clk) rst_d <= rst;

  assign known_mode = (bus_wdata[31:24] == 8'h03) || (bus_wdata[31:24] == 8'h0F) ||
                      (bus_wdata[31:24] == 8'h13);

  p_reset_state_r1: assert property (@(posedge clk)
    rst_d |-> (core_hold && !bus_rvalid));

  p_read_valid_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  p_page_gap_zero_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[15:14] == 2'b00));

  p_loaded_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata[31:24] == 8'h03) |=> core_hold);

  p_verified_releases_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata[31:24] == 8'h13) |=> !core_hold);

  p_unknown_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr || !known_mode) |=> $stable(core_hold));

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[31:24] == 8'h03 || bus_rdata[31:24] == 8'h0F ||
                    bus_rdata[31:24] == 8'h13));

  p_upload_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_wdata[31:24] == 8'h0F) |=> core_hold);
endmodule

bind fw_load_port fw_load_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .core_hold  (core_hold)
);

// File: tb/fw_load_port_tb.sv
`timescale 1ns/1ps
module fw_load_port_tb;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr, bus_rd;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          core_hold;
  logic [AW-1:0] core_addr;
  logic [7:0]    core_data;

  int compared   = 0;
  int mismatched = 0;
  logic [7:0] model [DEPTH];
  logic [31:0] got;

  always #2.5 clk = ~clk;

  fw_load_port #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .core_hold(core_hold), .core_addr(core_addr), .core_data(core_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] up_word(int a);
    return {8'h0F, model[a], 2'b00, 14'(a)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr_word(logic [31:0] w);
    bus_wr = 1'b1; bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_word(output logic [31:0] d);
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; core_addr = '0;
    repeat (4) @(negedge clk);
    check("R1 hold", {31'b0, core_hold}, 32'd1);
    check("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    rd_word(got);
    check("R1 first read", {got[31:24], 8'h00, got[15:0]}, 32'h0F000000);
    check("R3 rvalid", {31'b0, bus_rvalid}, 32'd1);

    // Host-style load: write each byte, read it straight back.
    wr_word(32'h0F000000);
    model[0] = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      wr_word({8'h0F, pat(i), 2'b11, 5'(i), 9'(i)});
      model[i] = pat(i);
      rd_word(got);
      check("R2 write-readback", got, {8'h0F, pat(i), 7'b0, 9'(i)});
    end
    rd_word(got);
    check("R4 wrap after load", got, up_word(0));

    // Verification sweep all the way around.
    for (int k = 1; k < DEPTH; k++) begin
      rd_word(got);
      check("R3 sweep", got, up_word(k));
    end
    rd_word(got);
    check("R4 wrap after sweep", got, up_word(0));

    // Pointer is 1: write naming page 1 lands in page 0.
    wr_word(32'h0FAA0105);
    model[5] = 8'hAA;
    rd_word(got);
    check("R5 page from pointer", got, 32'h0FAA0005);

    // Pointer is 6: simultaneous read and write.
    bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0F5C00C0;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R10 read sees old state", bus_rdata, up_word(6));
    model[8'hC0] = 8'h5C;
    rd_word(got);
    check("R10 write landed", got, up_word(8'hC0));
    rd_word(got);
    check("R10 pointer continues", got, up_word(8'hC1));

    // Unknown mode in upload.
    wr_word(32'h557700C2);
    check("R8 hold kept", {31'b0, core_hold}, 32'd1);
    rd_word(got);
    check("R8 no effect in upload", got, up_word(8'hC2));

    // Load complete.
    wr_word(32'h03990200);
    check("R6 hold kept", {31'b0, core_hold}, 32'd1);
    rd_word(got);
    check("R6 length readback", got, 32'h03000200);
    rd_word(got);
    check("R6 no advance", got, 32'h03000200);
    core_addr = '0;
    @(negedge clk);
    check("R6 RAM untouched", {24'b0, core_data}, {24'b0, model[0]});
    wr_word(32'h42330011);
    rd_word(got);
    check("R8 no effect when loaded", got, 32'h03000200);

    // Verified: core released.
    wr_word(32'h13000155);
    check("R7 hold released", {31'b0, core_hold}, 32'd0);
    rd_word(got);
    check("R7 readback", got, 32'h13000155);
    wr_word(32'h7F000000);
    check("R8 hold stays released", {31'b0, core_hold}, 32'd0);

    // Core fetch port over the whole image.
    for (int a = 0; a < DEPTH; a++) begin
      core_addr = AW'(a);
      @(negedge clk);
      check("R11 core fetch", {24'b0, core_data}, {24'b0, model[a]});
    end

    // Re-enter upload; pointer was left at 0xC3 so address becomes 0x000.
    wr_word(32'h0F000000);
    model[0] = 8'h00;
    check("R9 hold reasserted", {31'b0, core_hold}, 32'd1);
    rd_word(got);
    check("R9 upload readback", got, up_word(0));
    rd_word(got);
    check("R9 pointer advances", got, up_word(1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule